// File: doc/BRIEF.md
# AXI4-Lite to local-bus bridge

This block terminates AXI4-Lite slave traffic on all five channels and turns each transaction into one single-beat request on a simple local register bus. A write is issued only after both its address and its data beat have been taken in, in whichever order they arrive. A read is issued from a captured address. The bridge itself produces the write response and the read-data response, and both response codes are always OKAY.

The local bus has separate write and read signal groups, but the bridge runs at most one local operation at a time. Each request is held until the register side acknowledges it. When a read and a write are both waiting at the same time, the read is issued first. Protection attributes are taken in with their address but have no effect on the outcome. Address and data widths are parameters, and there is one byte-enable bit for each data byte.

Top module: `axil_lb_bridge`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, s_awready, s_wready and s_arready are 1, and s_bvalid, s_rvalid, lb_wr_req and lb_rd_req are 0.
- R2: An AW handshake and a W handshake may complete in either order or in the same cycle. lb_wr_req stays 0 until both have completed. A channel that has already completed its handshake holds its ready at 0 until the write finishes.
- R3: lb_wr_req stays 1, with lb_wr_addr, lb_wr_data and lb_wr_be held stable, until a cycle in which lb_wr_ack is 1. It is 0 in the following cycle. Each AXI write produces exactly one local write, so a write that waits N cycles for its acknowledge holds lb_wr_req for N+1 cycles.
- R4: lb_wr_addr equals the captured s_awaddr, lb_wr_data equals the captured s_wdata, and lb_wr_be equals the captured s_wstrb unchanged. Bit i of the byte enable governs data bits 8i+7 down to 8i.
- R5: s_bvalid goes to 1 in the cycle after the local write is acknowledged. It stays at 1 until s_bready is sampled at 1. s_bresp is 2'b00 whenever s_bvalid is 1. s_awready and s_wready are 0 while the response is pending.
- R6: lb_rd_req stays 1, with lb_rd_addr stable, until a cycle in which lb_rd_ack is 1, and it is 0 in the following cycle. lb_rd_data is captured in that acknowledge cycle. A read acknowledged N cycles after the request rose holds lb_rd_req for N+1 cycles.
- R7: s_rvalid goes to 1 in the cycle after the local read is acknowledged. It presents the captured data with s_rresp = 2'b00 and holds s_rdata stable until s_rready is sampled at 1. s_arready is 0 from the AR handshake until that R handshake.
- R8: s_awprot and s_arprot have no effect: a transaction with protection 3'b111 produces the same local address, data and strobes, and the same returned data, as one with protection 3'b000.
- R9: lb_wr_req and lb_rd_req are never 1 in the same cycle. When a read and a complete write are both waiting in the same cycle, the read is issued first, and it returns the data from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | AXI write address |
| s_awprot | input | 3 | AXI write protection (ignored) |
| s_awvalid | input | 1 | AXI write address valid |
| s_awready | output | 1 | AXI write address ready |
| s_wdata | input | DATA_W | AXI write data |
| s_wstrb | input | DATA_W/8 | AXI write byte strobes |
| s_wvalid | input | 1 | AXI write data valid |
| s_wready | output | 1 | AXI write data ready |
| s_bresp | output | 2 | AXI write response, always OKAY |
| s_bvalid | output | 1 | AXI write response valid |
| s_bready | input | 1 | AXI write response ready |
| s_araddr | input | ADDR_W | AXI read address |
| s_arprot | input | 3 | AXI read protection (ignored) |
| s_arvalid | input | 1 | AXI read address valid |
| s_arready | output | 1 | AXI read address ready |
| s_rdata | output | DATA_W | AXI read data |
| s_rresp | output | 2 | AXI read response, always OKAY |
| s_rvalid | output | 1 | AXI read data valid |
| s_rready | input | 1 | AXI read data ready |
| lb_wr_addr | output | ADDR_W | Local write address |
| lb_wr_data | output | DATA_W | Local write data |
| lb_wr_be | output | DATA_W/8 | Local write byte enables |
| lb_wr_req | output | 1 | Local write request, held until acknowledged |
| lb_wr_ack | input | 1 | Local write acknowledge |
| lb_rd_addr | output | ADDR_W | Local read address |
| lb_rd_req | output | 1 | Local read request, held until acknowledged |
| lb_rd_data | input | DATA_W | Local read data |
| lb_rd_ack | input | 1 | Local read data valid |

## Verification
A read request and a completed write can become ready for the local bus in the same cycle, and the scheduler must then choose one. The bench provokes this by presenting AW, W and AR on the same cycle, so that all three handshakes complete on one edge. It judges the result in two ways: the first local request to rise must be the read, and the returned data must equal the location's value from before the write. The write must then still reach the scoreboard with its own address, data and strobes.

// File: rtl/axlb_pkg.sv
// Package: shared types and constants for the AXI4-Lite to local-bus bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package axlb_pkg;

    // Local-bus scheduler states: at most one local operation at a time.
    typedef enum logic [1:0] {
        LB_IDLE  = 2'd0,
        LB_READ  = 2'd1,
        LB_WRITE = 2'd2
    } lb_state_e;

    // The only response code the bridge ever returns.
    localparam logic [1:0] AXI_RESP_OKAY = 2'b00;

endpackage

// File: rtl/axlb_wr_join.sv
// Module: axlb_wr_join
// Joins the independent AW and W handshakes into one pending write request.
// It holds the address, data and strobes stable until the local write is done,
// then raises the write response and keeps it up until the master takes it.
// Assumes: wr_done pulses only while wr_req is high.
module axlb_wr_join #(
    parameter  int ADDR_W = 16,
    parameter  int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    input  logic              wr_done
);

    logic aw_got;
    logic w_got;
    logic b_pend;

    // Each channel is open only while it holds nothing and no response waits.
    assign awready = !aw_got && !b_pend;
    assign wready  = !w_got  && !b_pend;
    assign wr_req  = aw_got && w_got;
    assign bvalid  = b_pend;

    // Purpose: capture the write address and hold it until the write is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_got  <= 1'b0;
            wr_addr <= '0;
        end else if (wr_done) begin
            aw_got  <= 1'b0;
        end else if (awvalid && awready) begin
            aw_got  <= 1'b1;
            wr_addr <= awaddr;
        end
    end

    // Purpose: capture the write data and strobes and hold them until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_got   <= 1'b0;
            wr_data <= '0;
            wr_strb <= '0;
        end else if (wr_done) begin
            w_got   <= 1'b0;
        end else if (wvalid && wready) begin
            w_got   <= 1'b1;
            wr_data <= wdata;
            wr_strb <= wstrb;
        end
    end

    // Purpose: raise the write response on completion, drop it on bready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_pend <= 1'b0;
        end else if (wr_done) begin
            b_pend <= 1'b1;
        end else if (b_pend && bready) begin
            b_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/axlb_rd_capture.sv
// Module: axlb_rd_capture
// Takes in one read address, requests it on the local bus through the
// scheduler, registers the returned data and presents it on the R channel
// until the master accepts it.
// Assumes: rd_done pulses only while rd_req is high.
module axlb_rd_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              rd_done
);

    logic ar_got;
    logic r_pend;

    // One read in flight: no new address until the last data is taken.
    assign arready = !ar_got && !r_pend;
    assign rd_req  = ar_got;
    assign rvalid  = r_pend;

    // Purpose: capture the read address and hold it until the data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_got  <= 1'b0;
            rd_addr <= '0;
        end else if (rd_done) begin
            ar_got  <= 1'b0;
        end else if (arvalid && arready) begin
            ar_got  <= 1'b1;
            rd_addr <= araddr;
        end
    end

    // Purpose: register the local read data and hold it until rready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_pend <= 1'b0;
            rdata  <= '0;
        end else if (rd_done) begin
            r_pend <= 1'b1;
            rdata  <= lb_data;
        end else if (r_pend && rready) begin
            r_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/axlb_lb_sched.sv
// Module: axlb_lb_sched
// Owns the local bus: it issues one request at a time and holds it until
// acknowledged. When both a read and a write are waiting, a parameter picks
// which goes first (read by default).
// Assumes: requests stay high until their done pulse.
module axlb_lb_sched #(
    parameter bit READ_FIRST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_req,
    input  logic lb_wr_ack,
    input  logic lb_rd_ack,
    output logic lb_wr_req,
    output logic lb_rd_req,
    output logic wr_done,
    output logic rd_done
);

    import axlb_pkg::*;

    lb_state_e state_q;
    lb_state_e state_d;
    logic      pick_read;

    // The priority rule is picked at elaboration.
    generate
        if (READ_FIRST) begin : g_read_first
            assign pick_read = rd_req;
        end else begin : g_write_first
            assign pick_read = rd_req && !wr_req;
        end
    endgenerate

    assign lb_rd_req = (state_q == LB_READ);
    assign lb_wr_req = (state_q == LB_WRITE);
    assign rd_done   = lb_rd_req && lb_rd_ack;
    assign wr_done   = lb_wr_req && lb_wr_ack;

    // Purpose: choose the next local operation or hold the current one.
    always_comb begin
        state_d = state_q;
        case (state_q)
            LB_IDLE: begin
                if (pick_read) begin
                    state_d = LB_READ;
                end else if (wr_req) begin
                    state_d = LB_WRITE;
                end
            end
            LB_READ: begin
                if (lb_rd_ack) begin
                    state_d = LB_IDLE;
                end
            end
            LB_WRITE: begin
                if (lb_wr_ack) begin
                    state_d = LB_IDLE;
                end
            end
            default: state_d = LB_IDLE;
        endcase
    end

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/axil_lb_bridge.sv
// Module: axil_lb_bridge (top)
// AXI4-Lite slave to single-transfer local register bus. One write and one
// read may be taken in at a time, but only one local operation runs at a time.
// Responses are always OKAY, and the protection inputs are ignored.
// Assumes: DATA_W is a multiple of 8; the local side acknowledges each request.
module axil_lb_bridge #(
    parameter  int ADDR_W     = 16,
    parameter  int DATA_W     = 32,
    parameter  bit READ_FIRST = 1'b1,
    localparam int STRB_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [ADDR_W-1:0] lb_wr_addr,
    output logic [DATA_W-1:0] lb_wr_data,
    output logic [STRB_W-1:0] lb_wr_be,
    output logic              lb_wr_req,
    input  logic              lb_wr_ack,
    output logic [ADDR_W-1:0] lb_rd_addr,
    output logic              lb_rd_req,
    input  logic [DATA_W-1:0] lb_rd_data,
    input  logic              lb_rd_ack
);

    import axlb_pkg::*;

    logic wr_pending;
    logic rd_pending;
    logic wr_done;
    logic rd_done;
    logic prot_unused;

    // Protection bits are accepted but deliberately go nowhere.
    assign prot_unused = ^{s_awprot, s_arprot};

    assign s_bresp = AXI_RESP_OKAY;
    assign s_rresp = AXI_RESP_OKAY;

    axlb_wr_join #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .wr_req  (wr_pending),
        .wr_addr (lb_wr_addr),
        .wr_data (lb_wr_data),
        .wr_strb (lb_wr_be),
        .wr_done (wr_done)
    );

    axlb_rd_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rd_req  (rd_pending),
        .rd_addr (lb_rd_addr),
        .lb_data (lb_rd_data),
        .rd_done (rd_done)
    );

    axlb_lb_sched #(
        .READ_FIRST (READ_FIRST)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_pending),
        .rd_req    (rd_pending),
        .lb_wr_ack (lb_wr_ack),
        .lb_rd_ack (lb_rd_ack),
        .lb_wr_req (lb_wr_req),
        .lb_rd_req (lb_rd_req),
        .wr_done   (wr_done),
        .rd_done   (rd_done)
    );

endmodule

// File: rtl/axlb_checker.sv
// Module: axlb_checker
// Protocol properties of the bridge, observed at its ports only.
// Assumes: bound into axil_lb_bridge by the bind statement at the end of this file.
module axlb_checker #(
    parameter  int ADDR_W = 16,
    parameter  int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awready,
    input logic              s_wready,
    input logic [1:0]        s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic              s_arready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [ADDR_W-1:0] lb_wr_addr,
    input logic [DATA_W-1:0] lb_wr_data,
    input logic [STRB_W-1:0] lb_wr_be,
    input logic              lb_wr_req,
    input logic              lb_wr_ack,
    input logic [ADDR_W-1:0] lb_rd_addr,
    input logic              lb_rd_req,
    input logic              lb_rd_ack
);

    // R2: a local write runs only with both AXI channels already captured.
    a_r2_both_captured: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr_req |-> (!s_awready && !s_wready));

    // R3: an unacknowledged write stays up with stable contents.
    a_r3_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_wr_req && !lb_wr_ack) |=> (lb_wr_req && $stable(lb_wr_addr)
                                       && $stable(lb_wr_data) && $stable(lb_wr_be)));

    // R3: an acknowledged write drops in the next cycle.
    a_r3_wr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_wr_req && lb_wr_ack) |=> !lb_wr_req);

    // R5: the write response stays until taken, with OKAY.
    a_r5_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    a_r5_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (s_bresp == 2'b00));

    a_r5_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (!s_awready && !s_wready));

    // R5: the response rises the cycle after the local acknowledge.
    a_r5_b_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_wr_req && lb_wr_ack) |=> s_bvalid);

    // R6: an unacknowledged read stays up with a stable address.
    a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd_req && !lb_rd_ack) |=> (lb_rd_req && $stable(lb_rd_addr)));

    // R7: read data is held stable until taken, with OKAY, and AR stays closed.
    a_r7_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    a_r7_rresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (s_rresp == 2'b00));

    a_r7_ar_closed: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);

    // R9: never two local operations at once.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lb_wr_req && lb_rd_req));

endmodule

bind axil_lb_bridge axlb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_awready  (s_awready),
    .s_wready   (s_wready),
    .s_bresp    (s_bresp),
    .s_bvalid   (s_bvalid),
    .s_bready   (s_bready),
    .s_arready  (s_arready),
    .s_rdata    (s_rdata),
    .s_rresp    (s_rresp),
    .s_rvalid   (s_rvalid),
    .s_rready   (s_rready),
    .lb_wr_addr (lb_wr_addr),
    .lb_wr_data (lb_wr_data),
    .lb_wr_be   (lb_wr_be),
    .lb_wr_req  (lb_wr_req),
    .lb_wr_ack  (lb_wr_ack),
    .lb_rd_addr (lb_rd_addr),
    .lb_rd_req  (lb_rd_req),
    .lb_rd_ack  (lb_rd_ack)
);

// File: tb/sim_axil_lb_bridge.sv
// Scoreboard bench: driver tasks queue the expected local writes and read
// data, and monitor processes pop and compare them as the bridge produces them.
module sim_axil_lb_bridge;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] s_awaddr = '0;
    logic [2:0]    s_awprot = '0;
    logic          s_awvalid = 1'b0;
    logic          s_awready;
    logic [DW-1:0] s_wdata = '0;
    logic [SW-1:0] s_wstrb = '0;
    logic          s_wvalid = 1'b0;
    logic          s_wready;
    logic [1:0]    s_bresp;
    logic          s_bvalid;
    logic          s_bready = 1'b0;
    logic [AW-1:0] s_araddr = '0;
    logic [2:0]    s_arprot = '0;
    logic          s_arvalid = 1'b0;
    logic          s_arready;
    logic [DW-1:0] s_rdata;
    logic [1:0]    s_rresp;
    logic          s_rvalid;
    logic          s_rready = 1'b0;
    logic [AW-1:0] lb_wr_addr;
    logic [DW-1:0] lb_wr_data;
    logic [SW-1:0] lb_wr_be;
    logic          lb_wr_req;
    logic          lb_wr_ack;
    logic [AW-1:0] lb_rd_addr;
    logic          lb_rd_req;
    logic [DW-1:0] lb_rd_data;
    logic          lb_rd_ack;

    always #5 clk = ~clk;

    axil_lb_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awprot(s_awprot), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arprot(s_arprot), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .lb_wr_addr(lb_wr_addr), .lb_wr_data(lb_wr_data), .lb_wr_be(lb_wr_be),
        .lb_wr_req(lb_wr_req), .lb_wr_ack(lb_wr_ack),
        .lb_rd_addr(lb_rd_addr), .lb_rd_req(lb_rd_req),
        .lb_rd_data(lb_rd_data), .lb_rd_ack(lb_rd_ack)
    );

    // ---------------- bookkeeping ----------------
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Inputs change 1 ns after the falling edge.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] init_word(input int i);
        return 32'hC0DE0000 | (i * 32'h00000101);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        end
        return r;
    endfunction

    // ---------------- local-bus slave model ----------------
    int wr_wait = 0;
    int rd_wait = 1;
    int wcnt;
    int rcnt;
    logic [31:0] lbmem [16];

    assign lb_wr_ack  = lb_wr_req && (wcnt == wr_wait);
    assign lb_rd_ack  = lb_rd_req && (rcnt == rd_wait);
    assign lb_rd_data = lb_rd_ack ? lbmem[lb_rd_addr[5:2]] : 32'hDEADBEEF;

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            rcnt <= 0;
            for (int i = 0; i < 16; i++) lbmem[i] <= init_word(i);
        end else begin
            wcnt <= (lb_wr_req && !lb_wr_ack) ? wcnt + 1 : 0;
            rcnt <= (lb_rd_req && !lb_rd_ack) ? rcnt + 1 : 0;
            if (lb_wr_req && lb_wr_ack)
                lbmem[lb_wr_addr[5:2]] <= merge(lbmem[lb_wr_addr[5:2]], lb_wr_data, lb_wr_be);
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } wexp_t;

    wexp_t       wq[$];
    logic [31:0] rq[$];
    logic [31:0] shadow [16];
    int          wen_cur = 0;
    int          wen_len = 0;
    int          ren_cur = 0;
    int          ren_len = 0;

    // Monitor: samples 1 ns before each rising edge.
    always begin
        @(negedge clk);
        #4;
        if (rst_n) begin
            if (lb_wr_req) wen_cur++;
            if (lb_rd_req) ren_cur++;
            if (lb_wr_req && lb_wr_ack) begin
                wen_len = wen_cur;
                wen_cur = 0;
                if (wq.size() == 0) begin
                    check(1'b0, "R4", "unexpected local write", {16'h0, lb_wr_addr}, 32'h0);
                end else begin
                    wexp_t e;
                    e = wq.pop_front();
                    check(lb_wr_addr == e.addr, "R4", "write address", {16'h0, lb_wr_addr}, {16'h0, e.addr});
                    check(lb_wr_data == e.data, "R4", "write data", lb_wr_data, e.data);
                    check(lb_wr_be == e.be, "R4", "write strobes", {28'h0, lb_wr_be}, {28'h0, e.be});
                end
            end
            if (lb_rd_req && lb_rd_ack) begin
                ren_len = ren_cur;
                ren_cur = 0;
            end
            if (s_rvalid && s_rready) begin
                if (rq.size() == 0) begin
                    check(1'b0, "R7", "unexpected read data", s_rdata, 32'h0);
                end else begin
                    logic [31:0] x;
                    x = rq.pop_front();
                    check(s_rdata == x, "R7", "read data", s_rdata, x);
                    check(s_rresp == 2'b00, "R7", "rresp", {30'h0, s_rresp}, 32'h0);
                end
            end
        end
    end

    // ---------------- AXI driver tasks ----------------
    task automatic send_aw(input logic [15:0] a, input logic [2:0] p);
        logic r;
        s_awaddr = a; s_awprot = p; s_awvalid = 1'b1;
        forever begin
            r = s_awready;
            step();
            if (r) break;
        end
        s_awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] be);
        logic r;
        s_wdata = d; s_wstrb = be; s_wvalid = 1'b1;
        forever begin
            r = s_wready;
            step();
            if (r) break;
        end
        s_wvalid = 1'b0;
    endtask

    task automatic send_ar(input logic [15:0] a, input logic [2:0] p);
        logic r;
        s_araddr = a; s_arprot = p; s_arvalid = 1'b1;
        forever begin
            r = s_arready;
            step();
            if (r) break;
        end
        s_arvalid = 1'b0;
    endtask

    task automatic expect_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
        wexp_t e;
        e.addr = a; e.data = d; e.be = be;
        wq.push_back(e);
        shadow[a[5:2]] = merge(shadow[a[5:2]], d, be);
    endtask

    // order: 0 = same cycle, 1 = AW first, 2 = W first
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be,
                            input logic [2:0] p, input int order, input int bhold);
        expect_write(a, d, be);
        if (order == 0) begin
            fork
                send_aw(a, p);
                send_w(d, be);
            join
        end else if (order == 1) begin
            send_aw(a, p);
            for (int k = 0; k < 3; k++) begin
                check(!lb_wr_req && !s_awready && s_wready, "R2", "AW alone must not start write",
                      {29'h0, lb_wr_req, s_awready, s_wready}, 32'h1);
                step();
            end
            send_w(d, be);
        end else begin
            send_w(d, be);
            for (int k = 0; k < 3; k++) begin
                check(!lb_wr_req && s_awready && !s_wready, "R2", "W alone must not start write",
                      {29'h0, lb_wr_req, s_awready, s_wready}, 32'h2);
                step();
            end
            send_aw(a, p);
        end
        for (int k = 0; k < 50 && !s_bvalid; k++) step();
        check(s_bvalid && s_bresp == 2'b00, "R5", "bvalid with OKAY",
              {29'h0, s_bvalid, s_bresp}, 32'h4);
        check(!s_awready && !s_wready, "R5", "AW/W closed while response pending",
              {30'h0, s_awready, s_wready}, 32'h0);
        for (int k = 0; k < bhold; k++) begin
            step();
            check(s_bvalid, "R5", "bvalid held without bready", {31'h0, s_bvalid}, 32'h1);
        end
        s_bready = 1'b1;
        step();
        s_bready = 1'b0;
        check(!s_bvalid, "R5", "bvalid drops after handshake", {31'h0, s_bvalid}, 32'h0);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [2:0] p, input int rhold);
        logic [31:0] first;
        rq.push_back(shadow[a[5:2]]);
        send_ar(a, p);
        for (int k = 0; k < 50 && !s_rvalid; k++) step();
        check(s_rvalid, "R7", "rvalid raised", {31'h0, s_rvalid}, 32'h1);
        first = s_rdata;
        for (int k = 0; k < rhold; k++) begin
            step();
            check(s_rvalid && s_rdata == first && !s_arready, "R7", "rdata held, AR closed",
                  s_rdata, first);
        end
        s_rready = 1'b1;
        step();
        s_rready = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        bit first_read;
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) step();
        check(s_awready && s_wready && s_arready && !s_bvalid && !s_rvalid && !lb_wr_req && !lb_rd_req,
              "R1", "values in reset",
              {25'h0, s_awready, s_wready, s_arready, s_bvalid, s_rvalid, lb_wr_req, lb_rd_req}, 32'h70);
        rst_n = 1'b1;
        step();
        check(s_awready && s_wready && s_arready && !s_bvalid && !s_rvalid && !lb_wr_req && !lb_rd_req,
              "R1", "values after reset",
              {25'h0, s_awready, s_wready, s_arready, s_bvalid, s_rvalid, lb_wr_req, lb_rd_req}, 32'h70);

        // R2/R4: three handshake orders, full and partial strobes
        do_write(16'h0004, 32'h11223344, 4'hF, 3'b000, 0, 0);
        do_write(16'h0008, 32'hAABBCCDD, 4'hF, 3'b000, 1, 0);
        do_write(16'h000C, 32'h55667788, 4'b0110, 3'b000, 2, 3);
        do_read(16'h000C, 3'b000, 0);
        do_read(16'h0004, 3'b000, 2);

        // R3: write acknowledge after 3 wait cycles
        wr_wait = 3;
        do_write(16'h0010, 32'h0BADF00D, 4'b1001, 3'b000, 0, 1);
        check(wen_len == 4, "R3", "write request cycles with 3 waits", wen_len, 32'd4);
        wr_wait = 0;
        do_read(16'h0010, 3'b000, 0);

        // R6: read acknowledge after 4 cycles
        rd_wait = 4;
        do_read(16'h0008, 3'b000, 3);
        check(ren_len == 5, "R6", "read request cycles with latency 4", ren_len, 32'd5);
        rd_wait = 1;

        // R8: protection bits have no effect
        do_write(16'h0014, 32'hFEEDFACE, 4'hF, 3'b111, 0, 0);
        do_read(16'h0014, 3'b111, 1);
        do_write(16'h0018, 32'h13579BDF, 4'b0011, 3'b101, 1, 0);
        do_read(16'h0018, 3'b010, 0);

        // R9: read and write ready in the same cycle; read goes first
        rd_wait = 2;
        rq.push_back(shadow[7]);
        expect_write(16'h001C, 32'h99990000, 4'hF);
        fork
            send_aw(16'h001C, 3'b000);
            send_w(32'h99990000, 4'hF);
            send_ar(16'h001C, 3'b000);
            begin
                for (int k = 0; k < 50 && !(lb_wr_req || lb_rd_req); k++) step();
                first_read = lb_rd_req && !lb_wr_req;
            end
        join
        check(first_read, "R9", "read issued before write", {31'h0, first_read}, 32'h1);
        s_bready = 1'b1;
        s_rready = 1'b1;
        repeat (20) step();
        s_bready = 1'b0;
        s_rready = 1'b0;
        check(!s_bvalid && !s_rvalid, "R9", "both responses delivered",
              {30'h0, s_bvalid, s_rvalid}, 32'h0);
        rd_wait = 1;
        do_read(16'h001C, 3'b000, 0);

        repeat (4) step();
        check(wq.size() == 0 && rq.size() == 0, "R4", "scoreboard drained",
              wq.size() + rq.size(), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule